// File: doc/BRIEF.md
# Time-Slotted Table Memory Arbiter

This block shares one single-port table memory among three clients: the frame forwarding and learning engine, the entry aging engine, and a host access port on the register bus. It does not arbitrate on demand. A free-running 16-cycle schedule says which client owns each cycle, so the frame rate does not depend on traffic from the other two clients.

The forwarding engine uses two frame contexts, 0 and 1. Each context reads its five-entry bucket in a burst of consecutive slots. Its two write-backs land in the idle gap of the other context. Two reserved slots per period serve the host port and the aging engine. Read results come back a fixed number of cycles after issue, tagged for the client that asked. A frame job offered to a context that is still holding one is discarded and counted. The schedule never waits.

The engine offers a frame job with a context number and a bucket index. It posts its two write-backs into that context's write buffer at any time. The background clients hold a request until their grant pulse appears.

Top module: `tdm_sram_arb`

## Requirements
- R1: `slot_o` counts 0 to 15 and wraps, advancing by one each cycle. It never stalls for any input pattern.
- R2: At most one memory operation is issued per cycle. `mem_en` is low in any slot whose owner has nothing to issue.
- R3: Context c reads in slots 8c+2 through 8c+6, word w (0..4) in slot 8c+2+w, at address {bucket, w}, where w fills the low 3 address bits. The slot 8c+2 read uses the job waiting in the context, which then becomes active. Slots 8c+3..8c+6 read only while a job is active.
- R4: Context 0 issues write-back entries 0 and 1 in slots 8 and 9. Context 1 issues them in slots 0 and 1. An issued entry is emptied. An empty entry leaves the slot idle. A new post to an entry replaces its contents, and a post in the cycle it is issued leaves it full with the new contents.
- R5: Slots 7 and 15 serve the host port when it requests. Otherwise they serve the aging engine, and they stay idle when neither requests. The granted client sees a one-cycle grant pulse in that slot, and its operation is driven on the memory port.
- R6: Host and aging requests in any other slot get no grant and do not change the memory port.
- R7: A read issued in cycle t raises exactly one return strobe in cycle t+RD_LAT (default 2), for the client that issued it. Forwarding returns carry the context and word number.
- R8: `fwd_ready[c]` is low while context c holds a job that has not started. A job offered to that context is dropped and `drop_cnt` increments, saturating at all ones.
- R9: During reset and until the second rising edge after `rst_n` is released, `slot_o` is 0, memory and grants are idle, both ready bits are high and `drop_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_start | input | 1 | Offer a frame job |
| fwd_ctx | input | 1 | Context for the offered job |
| fwd_bucket | input | ADDR_W-3 | Bucket index of the offered job |
| fwd_ready | output | 2 | Per context: can take a job |
| fwd_wr_valid | input | 1 | Post a write-back entry |
| fwd_wr_ctx | input | 1 | Context of the posted entry |
| fwd_wr_idx | input | 1 | Entry number 0 or 1 |
| fwd_wr_addr | input | ADDR_W | Write-back address |
| fwd_wr_data | input | DATA_W | Write-back data |
| age_req | input | 1 | Aging request, held until granted |
| age_we | input | 1 | Aging request is a write |
| age_addr | input | ADDR_W | Aging address |
| age_wdata | input | DATA_W | Aging write data |
| age_gnt | output | 1 | Aging request served this cycle |
| host_req | input | 1 | Host request, held until granted |
| host_we | input | 1 | Host request is a write |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_gnt | output | 1 | Host request served this cycle |
| mem_en | output | 1 | Memory operation this cycle |
| mem_we | output | 1 | Operation is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| fwd_rvalid | output | 1 | Read data on the memory bus belongs to forwarding |
| fwd_rctx | output | 1 | Context of that return |
| fwd_rword | output | 3 | Word number of that return |
| age_rvalid | output | 1 | Read data belongs to aging |
| host_rvalid | output | 1 | Read data belongs to the host |
| slot_o | output | 4 | Current schedule slot |
| drop_cnt | output | DROP_W | Saturating count of dropped jobs |

## Verification
The hardest case to reach is a job offered to a context in the same cycle its waiting job launches. A write-back posted in the very slot that drains the same entry is just as hard. Both need inputs aligned to one slot out of sixteen. Long random runs with frequent job offers and posts hit these alignments many times. A directed flood of jobs on one context drives the drop counter to saturation, and a directed phase holds both background requests high across several reserved slots.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int PERIOD    = 16;
  localparam int HALF      = PERIOD / 2;
  localparam int RD_FIRST  = 2;
  localparam int RD_WORDS  = 5;
  localparam int RESV_LO   = HALF - 1;

  typedef enum logic [1:0] {
    SK_RD = 2'd0,
    SK_WR = 2'd1,
    SK_BG = 2'd2
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic       ctx;
    logic [2:0] sub;
  } slot_dec_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_FWD  = 2'd1,
    OWN_AGE  = 2'd2,
    OWN_HOST = 2'd3
  } owner_e;

  typedef struct packed {
    owner_e     owner;
    logic       ctx;
    logic [2:0] word;
  } rd_tag_t;

  // Reads of context h sit at h*8+2..h*8+6, its writes spill into the
  // other half's slots 0 and 1, and slot 7 of each half is reserved.
  function automatic slot_dec_t decode_slot(input logic [3:0] s);
    slot_dec_t d;
    logic [2:0] lo;
    lo    = s[2:0];
    d.ctx = s[3];
    d.sub = 3'd0;
    if (lo == 3'(RESV_LO)) begin
      d.kind = SK_BG;
    end else if (lo >= 3'(RD_FIRST)) begin
      d.kind = SK_RD;
      d.sub  = lo - 3'(RD_FIRST);
    end else begin
      d.kind = SK_WR;
      d.ctx  = ~s[3];
      d.sub  = lo;
    end
    return d;
  endfunction

endpackage

// File: rtl/arb_slot_cnt.sv
module arb_slot_cnt (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] slot_q
);

  logic [3:0] slot_d;

  always_comb begin
    slot_d = slot_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 4'd0;
    end else begin
      slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/arb_frame_ctx.sv
module arb_frame_ctx
  import arb_pkg::*;
#(
  parameter bit CTX_ID = 1'b0,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORD_W = 3,
  parameter int BKT_W  = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_dec_t         dec,
  input  logic              start,
  input  logic [BKT_W-1:0]  bucket,
  output logic              ready,
  output logic              drop,
  input  logic              wr_valid,
  input  logic              wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int NWB = 2;

  logic             pend_q, pend_d, act_q, act_d;
  logic [BKT_W-1:0] pend_b_q, act_b_q;
  logic             accept, my_rd, my_wr, launch, last_rd;
  logic [BKT_W-1:0] rd_bkt;

  logic [NWB-1:0]   wb_v_q, wb_v_d, wb_load, wb_take;
  logic [ADDR_W-1:0] wb_a_q [NWB];
  logic [DATA_W-1:0] wb_d_q [NWB];

  always_comb begin
    my_rd   = (dec.kind == SK_RD) && (dec.ctx == CTX_ID);
    my_wr   = (dec.kind == SK_WR) && (dec.ctx == CTX_ID);
    launch  = my_rd && (dec.sub == 3'd0);
    last_rd = my_rd && (dec.sub == 3'(RD_WORDS - 1));
    ready   = ~pend_q;
    accept  = start && ~pend_q;
    drop    = start && pend_q;
    rd_bkt  = launch ? pend_b_q : act_b_q;
    rd_req  = my_rd && (launch ? pend_q : act_q);
    rd_word = WORD_W'(dec.sub);
    rd_addr = {rd_bkt, rd_word};
  end

  always_comb begin
    pend_d = pend_q;
    if (accept) begin
      pend_d = 1'b1;
    end else if (launch) begin
      pend_d = 1'b0;
    end
    act_d = act_q;
    if (launch) begin
      act_d = pend_q;
    end else if (last_rd) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pend_b_q <= bucket;
    end
    if (launch) begin
      act_b_q <= pend_b_q;
    end
  end

  for (genvar i = 0; i < NWB; i++) begin : g_wb
    always_comb begin
      wb_load[i] = wr_valid && (wr_idx == 1'(i));
      wb_take[i] = my_wr && (dec.sub[0] == 1'(i)) && wb_v_q[i];
      wb_v_d[i]  = wb_load[i] ? 1'b1 : (wb_take[i] ? 1'b0 : wb_v_q[i]);
    end

    always_ff @(posedge clk) begin
      if (wb_load[i]) begin
        wb_a_q[i] <= wr_addr;
        wb_d_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_v_q <= '0;
    end else begin
      wb_v_q <= wb_v_d;
    end
  end

  always_comb begin
    wr_req    = my_wr && wb_v_q[dec.sub[0]];
    wr_addr_o = wb_a_q[dec.sub[0]];
    wr_data_o = wb_d_q[dec.sub[0]];
  end

endmodule

// File: rtl/arb_tag_pipe.sv
module arb_tag_pipe
  import arb_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  rd_tag_t tag_in,
  output rd_tag_t tag_out
);

  rd_tag_t stage_q [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    rd_tag_t stage_d;
    if (i == 0) begin : g_head
      always_comb stage_d = tag_in;
    end else begin : g_body
      always_comb stage_d = stage_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= '{owner: OWN_NONE, ctx: 1'b0, word: 3'd0};
      end else begin
        stage_q[i] <= stage_d;
      end
    end
  end

  always_comb tag_out = stage_q[LAT-1];

endmodule

// File: rtl/tdm_sram_arb.sv
module tdm_sram_arb
  import arb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int RD_LAT = 2,
  parameter int DROP_W = 8,
  localparam int WORD_W = $clog2(RD_WORDS),
  localparam int BKT_W  = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_start,
  input  logic              fwd_ctx,
  input  logic [BKT_W-1:0]  fwd_bucket,
  output logic [1:0]        fwd_ready,
  input  logic              fwd_wr_valid,
  input  logic              fwd_wr_ctx,
  input  logic              fwd_wr_idx,
  input  logic [ADDR_W-1:0] fwd_wr_addr,
  input  logic [DATA_W-1:0] fwd_wr_data,
  input  logic              age_req,
  input  logic              age_we,
  input  logic [ADDR_W-1:0] age_addr,
  input  logic [DATA_W-1:0] age_wdata,
  output logic              age_gnt,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_gnt,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fwd_rvalid,
  output logic              fwd_rctx,
  output logic [WORD_W-1:0] fwd_rword,
  output logic              age_rvalid,
  output logic              host_rvalid,
  output logic [3:0]        slot_o,
  output logic [DROP_W-1:0] drop_cnt
);

  localparam int NCTX = 2;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic [3:0] slot_q;
  slot_dec_t  dec;

  arb_slot_cnt u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .slot_q (slot_q)
  );

  always_comb begin
    dec    = decode_slot(slot_q);
    slot_o = slot_q;
  end

  logic [NCTX-1:0]   c_drop, c_rd, c_wr;
  logic [ADDR_W-1:0] c_rd_addr [NCTX];
  logic [WORD_W-1:0] c_rd_word [NCTX];
  logic [ADDR_W-1:0] c_wr_addr [NCTX];
  logic [DATA_W-1:0] c_wr_data [NCTX];

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    arb_frame_ctx #(
      .CTX_ID (1'(c)),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WORD_W (WORD_W),
      .BKT_W  (BKT_W)
    ) u_ctx (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .dec       (dec),
      .start     (fwd_start && (fwd_ctx == 1'(c))),
      .bucket    (fwd_bucket),
      .ready     (fwd_ready[c]),
      .drop      (c_drop[c]),
      .wr_valid  (fwd_wr_valid && (fwd_wr_ctx == 1'(c))),
      .wr_idx    (fwd_wr_idx),
      .wr_addr   (fwd_wr_addr),
      .wr_data   (fwd_wr_data),
      .rd_req    (c_rd[c]),
      .rd_addr   (c_rd_addr[c]),
      .rd_word   (c_rd_word[c]),
      .wr_req    (c_wr[c]),
      .wr_addr_o (c_wr_addr[c]),
      .wr_data_o (c_wr_data[c])
    );
  end

  // memory port mux: the slot decode selects exactly one source
  rd_tag_t tag_now, tag_ret;
  logic    bg_slot;

  always_comb begin
    bg_slot   = (dec.kind == SK_BG);
    host_gnt  = bg_slot && host_req;
    age_gnt   = bg_slot && age_req && !host_req;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    tag_now   = '{owner: OWN_NONE, ctx: dec.ctx, word: 3'd0};
    unique case (dec.kind)
      SK_RD: begin
        mem_en        = c_rd[dec.ctx];
        mem_addr      = c_rd_addr[dec.ctx];
        tag_now.word  = 3'(c_rd_word[dec.ctx]);
        tag_now.owner = c_rd[dec.ctx] ? OWN_FWD : OWN_NONE;
      end
      SK_WR: begin
        mem_en    = c_wr[dec.ctx];
        mem_we    = c_wr[dec.ctx];
        mem_addr  = c_wr_addr[dec.ctx];
        mem_wdata = c_wr_data[dec.ctx];
      end
      SK_BG: begin
        if (host_gnt) begin
          mem_en        = 1'b1;
          mem_we        = host_we;
          mem_addr      = host_addr;
          mem_wdata     = host_wdata;
          tag_now.owner = host_we ? OWN_NONE : OWN_HOST;
        end else if (age_gnt) begin
          mem_en        = 1'b1;
          mem_we        = age_we;
          mem_addr      = age_addr;
          mem_wdata     = age_wdata;
          tag_now.owner = age_we ? OWN_NONE : OWN_AGE;
        end
      end
      default: ;
    endcase
  end

  arb_tag_pipe #(.LAT(RD_LAT)) u_tags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tag_in  (tag_now),
    .tag_out (tag_ret)
  );

  always_comb begin
    fwd_rvalid  = (tag_ret.owner == OWN_FWD);
    age_rvalid  = (tag_ret.owner == OWN_AGE);
    host_rvalid = (tag_ret.owner == OWN_HOST);
    fwd_rctx    = tag_ret.ctx;
    fwd_rword   = WORD_W'(tag_ret.word);
  end

  // saturating count of discarded frame jobs
  logic              drop_hit, drop_en;
  logic [DROP_W-1:0] drop_d;

  always_comb begin
    drop_hit = |c_drop;
    drop_en  = drop_hit && (drop_cnt != {DROP_W{1'b1}});
    drop_d   = drop_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      drop_cnt <= '0;
    end else if (drop_en) begin
      drop_cnt <= drop_d;
    end
  end

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int WORD_W = 3,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        slot_o,
  input logic              mem_en,
  input logic              mem_we,
  input logic              age_gnt,
  input logic              host_gnt,
  input logic              fwd_rvalid,
  input logic              age_rvalid,
  input logic              host_rvalid,
  input logic [WORD_W-1:0] fwd_rword,
  input logic [DROP_W-1:0] drop_cnt
);

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot_o == 4'($past(slot_o) + 4'd1)); // R1

  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(age_gnt && host_gnt)); // R5

  AST_GNT_IN_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (age_gnt || host_gnt) |-> (slot_o[2:0] == 3'd7) && mem_en); // R5

  AST_NO_BG_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o[2:0] != 3'd7) |-> !(age_gnt || host_gnt)); // R6

  AST_WR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (slot_o[2:0] <= 3'd1 || slot_o[2:0] == 3'd7)); // R4

  AST_RD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (slot_o[2:0] >= 3'd2)); // R3

  AST_RET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_rvalid, age_rvalid, host_rvalid})); // R7

  AST_RET_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_rvalid |-> (fwd_rword < WORD_W'(5))); // R7

  AST_DROP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_cnt >= $past(drop_cnt)); // R8

endmodule

bind tdm_sram_arb arb_checker #(
  .WORD_W (WORD_W),
  .DROP_W (DROP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .slot_o      (slot_o),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .age_gnt     (age_gnt),
  .host_gnt    (host_gnt),
  .fwd_rvalid  (fwd_rvalid),
  .age_rvalid  (age_rvalid),
  .host_rvalid (host_rvalid),
  .fwd_rword   (fwd_rword),
  .drop_cnt    (drop_cnt)
);

// File: tb/sim_tdm_sram_arb.sv
`timescale 1ns/1ps
module sim_tdm_sram_arb;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int LAT    = 2;
  localparam int DROP_W = 8;
  localparam int WORD_W = 3;
  localparam int BKT_W  = ADDR_W - WORD_W;
  localparam int DMAX   = (1 << DROP_W) - 1;

  logic clk, rst_n;
  logic fwd_start, fwd_ctx, fwd_wr_valid, fwd_wr_ctx, fwd_wr_idx;
  logic [BKT_W-1:0] fwd_bucket;
  logic [1:0] fwd_ready;
  logic [ADDR_W-1:0] fwd_wr_addr, age_addr, host_addr, mem_addr;
  logic [DATA_W-1:0] fwd_wr_data, age_wdata, host_wdata, mem_wdata;
  logic age_req, age_we, age_gnt, host_req, host_we, host_gnt;
  logic mem_en, mem_we, fwd_rvalid, fwd_rctx, age_rvalid, host_rvalid;
  logic [WORD_W-1:0] fwd_rword;
  logic [3:0] slot_o;
  logic [DROP_W-1:0] drop_cnt;

  tdm_sram_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(LAT), .DROP_W(DROP_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fwd_start(fwd_start), .fwd_ctx(fwd_ctx), .fwd_bucket(fwd_bucket), .fwd_ready(fwd_ready),
    .fwd_wr_valid(fwd_wr_valid), .fwd_wr_ctx(fwd_wr_ctx), .fwd_wr_idx(fwd_wr_idx),
    .fwd_wr_addr(fwd_wr_addr), .fwd_wr_data(fwd_wr_data),
    .age_req(age_req), .age_we(age_we), .age_addr(age_addr), .age_wdata(age_wdata), .age_gnt(age_gnt),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_gnt(host_gnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fwd_rvalid(fwd_rvalid), .fwd_rctx(fwd_rctx), .fwd_rword(fwd_rword),
    .age_rvalid(age_rvalid), .host_rvalid(host_rvalid),
    .slot_o(slot_o), .drop_cnt(drop_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errs   = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference state, from the requirements
  bit              m_pv [2];
  bit [BKT_W-1:0]  m_pb [2];
  bit              m_av [2];
  bit [BKT_W-1:0]  m_ab [2];
  bit              m_wv [2][2];
  bit [ADDR_W-1:0] m_wa [2][2];
  bit [DATA_W-1:0] m_wd [2][2];
  int              m_drop, m_slot;
  int              t_own [LAT];   // 0 none, 1 fwd, 2 age, 3 host
  int              t_ctx [LAT];
  int              t_word [LAT];

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_pv[c] = 0; m_av[c] = 0;
      for (int i = 0; i < 2; i++) m_wv[c][i] = 0;
    end
    m_drop = 0; m_slot = 0;
    for (int k = 0; k < LAT; k++) t_own[k] = 0;
  endtask

  function automatic bit [ADDR_W-1:0] rd_adr(input bit [BKT_W-1:0] b, input int w);
    return {b, 3'(w)};
  endfunction

  task automatic drive_idle();
    fwd_start = 0; fwd_ctx = 0; fwd_bucket = '0; fwd_wr_valid = 0; fwd_wr_ctx = 0;
    fwd_wr_idx = 0; fwd_wr_addr = '0; fwd_wr_data = '0;
    age_req = 0; age_we = 0; age_addr = '0; age_wdata = '0;
    host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0;
  endtask

  // mode 0 random, 1 both background clients held, 2 job flood on context 0
  task automatic run_cycle(input int mode);
    int lo, hi, c, w, own, e_ctx, e_word;
    bit e_en, e_we, e_ag, e_hg, v;
    bit [ADDR_W-1:0] e_addr;
    bit [DATA_W-1:0] e_wd;
    bit [BKT_W-1:0] b;
    bit old_pv [2];
    @(negedge clk);
    drive_idle();
    if (mode == 0) begin
      fwd_start    = ($urandom % 5) == 0;
      fwd_ctx      = 1'($urandom);
      fwd_bucket   = BKT_W'($urandom);
      fwd_wr_valid = ($urandom % 4) == 0;
      fwd_wr_ctx   = 1'($urandom);
      fwd_wr_idx   = 1'($urandom);
      fwd_wr_addr  = ADDR_W'($urandom);
      fwd_wr_data  = $urandom;
      age_req  = 1'($urandom); age_we  = 1'($urandom);
      age_addr = ADDR_W'($urandom); age_wdata = $urandom;
      host_req = ($urandom % 3) == 0; host_we = 1'($urandom);
      host_addr = ADDR_W'($urandom); host_wdata = $urandom;
    end else if (mode == 1) begin
      age_req = 1; age_we = 0; age_addr = 12'h0a5;
      host_req = 1; host_we = 0; host_addr = 12'h35a;
    end else begin
      fwd_start = 1; fwd_ctx = 0; fwd_bucket = BKT_W'($urandom);
    end
    #1;
    lo = m_slot % 8; hi = m_slot / 8;
    e_en = 0; e_we = 0; e_addr = '0; e_wd = '0; e_ag = 0; e_hg = 0;
    own = 0; e_ctx = 0; e_word = 0; c = 0; w = 0;
    if (lo >= 2 && lo <= 6) begin
      c = hi; w = lo - 2;
      v = (w == 0) ? m_pv[c] : m_av[c];
      b = (w == 0) ? m_pb[c] : m_ab[c];
      if (v) begin e_en = 1; e_addr = rd_adr(b, w); own = 1; e_ctx = c; e_word = w; end
    end else if (lo <= 1) begin
      c = 1 - hi; w = lo;
      if (m_wv[c][w]) begin e_en = 1; e_we = 1; e_addr = m_wa[c][w]; e_wd = m_wd[c][w]; end
    end else begin
      if (host_req) begin
        e_hg = 1; e_en = 1; e_we = host_we; e_addr = host_addr; e_wd = host_wdata;
        own = host_we ? 0 : 3;
      end else if (age_req) begin
        e_ag = 1; e_en = 1; e_we = age_we; e_addr = age_addr; e_wd = age_wdata;
        own = age_we ? 0 : 2;
      end
    end
    chk("R1", "slot_o", slot_o, m_slot);
    chk("R2", "mem_en", mem_en, e_en);
    if (e_en) begin
      chk("R3/R4/R5", "mem_we", mem_we, e_we);
      chk("R3/R4/R5", "mem_addr", mem_addr, e_addr);
      if (e_we) chk("R4/R5", "mem_wdata", mem_wdata, e_wd);
    end
    chk("R5", "host_gnt", host_gnt, e_hg);
    chk("R5", "age_gnt", age_gnt, e_ag);
    chk("R8", "fwd_ready", fwd_ready, {~m_pv[1], ~m_pv[0]});
    chk("R7", "fwd_rvalid", fwd_rvalid, t_own[LAT-1] == 1);
    chk("R7", "age_rvalid", age_rvalid, t_own[LAT-1] == 2);
    chk("R7", "host_rvalid", host_rvalid, t_own[LAT-1] == 3);
    if (t_own[LAT-1] == 1) begin
      chk("R7", "fwd_rctx", fwd_rctx, t_ctx[LAT-1]);
      chk("R7", "fwd_rword", fwd_rword, t_word[LAT-1]);
    end
    chk("R8", "drop_cnt", drop_cnt, m_drop);
    // advance the reference model across the coming edge
    old_pv = m_pv;
    if (lo >= 2 && lo <= 6) begin
      if (w == 0 && old_pv[c]) begin m_av[c] = 1; m_ab[c] = m_pb[c]; m_pv[c] = 0; end
      if (w == 4) m_av[c] = 0;
    end else if (lo <= 1) begin
      m_wv[c][w] = 0;
    end
    if (fwd_wr_valid) begin
      m_wv[fwd_wr_ctx][fwd_wr_idx] = 1;
      m_wa[fwd_wr_ctx][fwd_wr_idx] = fwd_wr_addr;
      m_wd[fwd_wr_ctx][fwd_wr_idx] = fwd_wr_data;
    end
    if (fwd_start) begin
      if (!old_pv[fwd_ctx]) begin m_pv[fwd_ctx] = 1; m_pb[fwd_ctx] = fwd_bucket; end
      else if (m_drop < DMAX) m_drop++;
    end
    for (int k = LAT - 1; k > 0; k--) begin
      t_own[k] = t_own[k-1]; t_ctx[k] = t_ctx[k-1]; t_word[k] = t_word[k-1];
    end
    t_own[0] = own; t_ctx[0] = e_ctx; t_word[0] = e_word;
    m_slot = (m_slot + 1) % 16;
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a1b));
    drive_idle();
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state, background requests asserted to show no grant
    age_req = 1; host_req = 1; fwd_start = 1;
    #1;
    chk("R9", "slot_o in reset", slot_o, 0);
    chk("R9", "mem_en in reset", mem_en, 0);
    chk("R9", "grants in reset", {age_gnt, host_gnt}, 0);
    chk("R9", "fwd_ready in reset", fwd_ready, 3);
    chk("R9", "drop_cnt in reset", drop_cnt, 0);
    drive_idle();
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "slot held after release", slot_o, 0);
    @(posedge clk);
    // internal reset now released, slot still 0
    for (int n = 0; n < 3000; n++) run_cycle(0);
    for (int n = 0; n < 40; n++) run_cycle(1);
    for (int n = 0; n < 400; n++) run_cycle(2);
    for (int n = 0; n < 200; n++) run_cycle(0);
    chk("R8", "drop_cnt saturated", drop_cnt, DMAX);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule